// File: doc/BRIEF.md
# Readout trigger and power-pulse controller

This block runs acquisition control for a 32-channel readout module. It chooses among three trigger sources: an external trigger line, a self-trigger raised when any ADC sample rises above a programmable threshold, and a command from software. Each accepted trigger leaves the block as a one-cycle pulse with a 2-bit tag that names its source. After a trigger, a programmable dead time rejects further requests.

The block also drives the power-pulsing enable for the front-end and ADC chips. Power follows a fixed window, by default 1 ms on and 199 ms off, timed from a 1 µs tick that is divided down from the system clock. Triggers are accepted only while power is on, and only after a programmable settling delay that follows power-up. A clock-select output picks between the internal free-running ADC clock (0) and the external beam-synchronous clock (1). That output follows its request only while power is off, so the ADC clock never switches during acquisition.

Two state machines carry the control. The power sequencer has the states PWR_OFF, PWR_SETTLE and PWR_ARMED. Its transitions are: off-window expiry, PWR_OFF to PWR_SETTLE; settle delay reached, PWR_SETTLE to PWR_ARMED; on-window expiry, PWR_SETTLE or PWR_ARMED to PWR_OFF. The trigger arbiter has the states TRG_IDLE, TRG_FIRE and TRG_DEAD. Its transitions are: enabled request while armed, TRG_IDLE to TRG_FIRE; TRG_FIRE to TRG_DEAD when the dead time is nonzero, otherwise to TRG_IDLE; dead counter expired, TRG_DEAD to TRG_IDLE.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: During and right after reset, pwr_en_o, trig_o, trig_src_o and clk_sel_o are all 0.
- R2: pwr_en_o starts low after reset. It then alternates between OFF_US·CLK_PER_US cycles low and ON_US·CLK_PER_US cycles high.
- R3: No trigger pulse is produced while power is off. A trig_o pulse is only ever preceded by a cycle with pwr_en_o high.
- R4: Requests are ignored for the first settle_us_i·CLK_PER_US+1 cycles after pwr_en_o rises.
- R5: A rising edge on ext_trig_i produces trig_o two clock edges later, with tag 2'b01. A level held high yields only one trigger.
- R6: The self-trigger fires when any channel sample is strictly greater than threshold_i, with tag 2'b10. A sample equal to the threshold does not fire. A sustained over-threshold condition, even if it spreads to more channels, yields one trigger until all channels fall back.
- R7: A software request (sw_trig_i high) produces trig_o two edges later with tag 2'b11.
- R8: src_enable_i bit 0 enables the external source, bit 1 the self-trigger, and bit 2 software. A request from a disabled source produces no trigger.
- R9: When several enabled sources request in the same cycle, the tag is chosen in the priority order external, then self, then software.
- R10: After a trigger pulse, requests are dropped for the following dead_cycles_i cycles. A request after that window fires again.
- R11: trig_o is a single-cycle pulse. trig_src_o is nonzero exactly while trig_o is high.
- R12: clk_sel_o takes the value of clk_sel_req_i only while power is off. A change of the request while power is on has no effect until power goes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_trig_i | input | 1 | External trigger line, rising edge counts |
| sw_trig_i | input | 1 | Software trigger request |
| samples_i | input | NUM_CH·SAMPLE_W | Packed samples, channel c at bits c·SAMPLE_W upward |
| threshold_i | input | SAMPLE_W | Self-trigger threshold |
| src_enable_i | input | 3 | Source enable mask: bit0 external, bit1 self, bit2 software |
| settle_us_i | input | SETTLE_W | Settling delay after power-up, in µs ticks |
| dead_cycles_i | input | DEAD_W | Dead time after a trigger, in clock cycles |
| clk_sel_req_i | input | 1 | Requested ADC clock source |
| trig_o | output | 1 | Trigger pulse |
| trig_src_o | output | 2 | Source tag: 01 external, 10 self, 11 software, 00 none |
| pwr_en_o | output | 1 | Power-pulsing enable |
| clk_sel_o | output | 1 | ADC clock select: 0 internal, 1 external |

## Verification
The trigger function is driven with a lone external edge held high, a sample exactly at the threshold and then one above it, a growing over-threshold spread across channels, single software pulses, and simultaneous external and software requests under different masks. Together these separate level sensitivity from edge qualification, strict comparison from non-strict comparison, and priority from masking. Requests placed during power-off, just after power-up, and inside the dead window confirm that each gate drops them. Requests placed after each gate lifts confirm that the gate releases. Measuring whole power windows checks the tick division and the counter wrap against their parameters.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_SELF = 2'b10,
        SRC_SW   = 2'b11
    } trig_src_e;

    typedef enum logic [1:0] {
        PWR_OFF    = 2'b00,
        PWR_SETTLE = 2'b01,
        PWR_ARMED  = 2'b10
    } pwr_state_e;

    typedef enum logic [1:0] {
        TRG_IDLE = 2'b00,
        TRG_FIRE = 2'b01,
        TRG_DEAD = 2'b10
    } trg_state_e;

endpackage

// File: rtl/acq_us_tick.sv
module acq_us_tick #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = (div_q == DIV_LAST);
endmodule

// File: rtl/acq_power_seq.sv
module acq_power_seq
    import acq_trig_pkg::*;
#(
    parameter int ON_US    = 1000,
    parameter int OFF_US   = 199000,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [SETTLE_W-1:0] settle_us_i,
    output logic                pwr_en_o,
    output logic                armed_o
);
    localparam int MAX_US = (ON_US > OFF_US) ? ON_US : OFF_US;
    localparam int CNT_W  = $clog2(MAX_US + 1);
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_US - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_US - 1);

    pwr_state_e       state_q, state_d;
    logic [CNT_W-1:0] us_q;
    logic             window_end;
    logic             settled;

    assign window_end = tick_i && ((state_q == PWR_OFF) ? (us_q == OFF_LAST)
                                                        : (us_q == ON_LAST));
    assign settled    = 32'(us_q) >= 32'(settle_us_i);

    // state register and window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_OFF;
            us_q    <= '0;
        end else begin
            state_q <= state_d;
            if (window_end) begin
                us_q <= '0;
            end else if (tick_i) begin
                us_q <= us_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_OFF:    if (window_end) state_d = PWR_SETTLE;
            PWR_SETTLE: begin
                if (window_end)   state_d = PWR_OFF;
                else if (settled) state_d = PWR_ARMED;
            end
            PWR_ARMED:  if (window_end) state_d = PWR_OFF;
            default:    state_d = PWR_OFF;
        endcase
    end

    // outputs
    always_comb begin
        pwr_en_o = (state_q != PWR_OFF);
        armed_o  = (state_q == PWR_ARMED);
    end
endmodule

// File: rtl/acq_thresh_detect.sv
module acq_thresh_detect #(
    parameter int NUM_CH   = 32,
    parameter int SAMPLE_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
    input  logic [SAMPLE_W-1:0]        threshold_i,
    output logic                       rise_o
);
    logic [NUM_CH-1:0] over;
    logic              any_q, any_qq;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign over[c] = samples_i[c*SAMPLE_W +: SAMPLE_W] > threshold_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q  <= 1'b0;
            any_qq <= 1'b0;
        end else begin
            any_q  <= |over;
            any_qq <= any_q;
        end
    end

    assign rise_o = any_q & ~any_qq;
endmodule

// File: rtl/acq_trig_arbiter.sv
module acq_trig_arbiter
    import acq_trig_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed_i,
    input  logic [2:0]        req_i,
    input  logic [2:0]        enable_i,
    input  logic [DEAD_W-1:0] dead_cycles_i,
    output logic              trig_o,
    output logic [1:0]        trig_src_o
);
    trg_state_e        state_q, state_d;
    trig_src_e         tag_q, pick;
    logic [DEAD_W-1:0] dead_q;
    logic [2:0]        live;

    assign live = req_i & enable_i;

    always_comb begin
        if (live[0])      pick = SRC_EXT;
        else if (live[1]) pick = SRC_SELF;
        else if (live[2]) pick = SRC_SW;
        else              pick = SRC_NONE;
    end

    // state register, tag and dead counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRG_IDLE;
            tag_q   <= SRC_NONE;
            dead_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TRG_IDLE && state_d == TRG_FIRE) begin
                tag_q <= pick;
            end
            if (state_q == TRG_FIRE) begin
                dead_q <= dead_cycles_i - 1'b1;
            end else if (state_q == TRG_DEAD && dead_q != '0) begin
                dead_q <= dead_q - 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_IDLE: if (armed_i && live != 3'b000) state_d = TRG_FIRE;
            TRG_FIRE: state_d = (dead_cycles_i != '0) ? TRG_DEAD : TRG_IDLE;
            TRG_DEAD: if (dead_q == '0) state_d = TRG_IDLE;
            default:  state_d = TRG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        trig_o     = (state_q == TRG_FIRE);
        trig_src_o = (state_q == TRG_FIRE) ? tag_q : SRC_NONE;
    end
endmodule

// File: rtl/acq_trigger_ctrl.sv
module acq_trigger_ctrl #(
    parameter int NUM_CH     = 32,
    parameter int SAMPLE_W   = 10,
    parameter int CLK_PER_US = 125,
    parameter int ON_US      = 1000,
    parameter int OFF_US     = 199000,
    parameter int SETTLE_W   = 8,
    parameter int DEAD_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ext_trig_i,
    input  logic                       sw_trig_i,
    input  logic [NUM_CH*SAMPLE_W-1:0] samples_i,
    input  logic [SAMPLE_W-1:0]        threshold_i,
    input  logic [2:0]                 src_enable_i,
    input  logic [SETTLE_W-1:0]        settle_us_i,
    input  logic [DEAD_W-1:0]          dead_cycles_i,
    input  logic                       clk_sel_req_i,
    output logic                       trig_o,
    output logic [1:0]                 trig_src_o,
    output logic                       pwr_en_o,
    output logic                       clk_sel_o
);
    logic tick;
    logic armed;
    logic self_rise;
    logic ext_q, ext_qq, sw_q;
    logic clk_sel_q;

    acq_us_tick #(.CLK_PER_US(CLK_PER_US)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    acq_power_seq #(
        .ON_US    (ON_US),
        .OFF_US   (OFF_US),
        .SETTLE_W (SETTLE_W)
    ) pwr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .settle_us_i (settle_us_i),
        .pwr_en_o    (pwr_en_o),
        .armed_o     (armed)
    );

    acq_thresh_detect #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W)
    ) thr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .samples_i   (samples_i),
        .threshold_i (threshold_i),
        .rise_o      (self_rise)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q     <= 1'b0;
            ext_qq    <= 1'b0;
            sw_q      <= 1'b0;
            clk_sel_q <= 1'b0;
        end else begin
            ext_q  <= ext_trig_i;
            ext_qq <= ext_q;
            sw_q   <= sw_trig_i;
            if (!pwr_en_o) clk_sel_q <= clk_sel_req_i;
        end
    end

    acq_trig_arbiter #(.DEAD_W(DEAD_W)) arb_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .armed_i       (armed),
        .req_i         ({sw_q, self_rise, ext_q & ~ext_qq}),
        .enable_i      (src_enable_i),
        .dead_cycles_i (dead_cycles_i),
        .trig_o        (trig_o),
        .trig_src_o    (trig_src_o)
    );

    assign clk_sel_o = clk_sel_q;
endmodule

// File: rtl/acq_trigger_ctrl_chk.sv
module acq_trigger_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_o,
    input logic [1:0] trig_src_o,
    input logic       pwr_en_o,
    input logic       clk_sel_o,
    input logic [2:0] src_enable_i
);
    // R3
    trig_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(pwr_en_o));

    // R11
    trig_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R11
    tag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (trig_src_o != 2'b00));

    // R11
    tag_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_o |-> (trig_src_o == 2'b00));

    // R12
    clk_sel_off_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel_o) |-> !$past(pwr_en_o));

    // R8
    ext_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && trig_src_o == 2'b01) |-> $past(src_enable_i[0]));

    // R8
    sw_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && trig_src_o == 2'b11) |-> $past(src_enable_i[2]));
endmodule

bind acq_trigger_ctrl acq_trigger_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_o       (trig_o),
    .trig_src_o   (trig_src_o),
    .pwr_en_o     (pwr_en_o),
    .clk_sel_o    (clk_sel_o),
    .src_enable_i (src_enable_i)
);

// File: tb/acq_trigger_ctrl_tb_top.sv
`timescale 1ns/1ps
module acq_trigger_ctrl_tb_top;
    localparam int NCH = 32;
    localparam int SW  = 10;
    localparam int CPU = 4;
    localparam int ONU = 60;
    localparam int OFFU = 40;
    localparam int SETTLE = 2;
    localparam int DEAD = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_trig = 1'b0;
    logic          sw_trig = 1'b0;
    logic [NCH*SW-1:0] samples = '0;
    logic [SW-1:0] threshold = 10'd500;
    logic [2:0]    enable = 3'b111;
    logic [7:0]    settle = 8'(SETTLE);
    logic [7:0]    dead = 8'(DEAD);
    logic          clk_sel_req = 1'b0;
    logic          trig;
    logic [1:0]    trig_src;
    logic          pwr_en;
    logic          clk_sel;

    int total = 0;
    int fails = 0;
    int trig_count = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acq_trigger_ctrl #(
        .NUM_CH(NCH), .SAMPLE_W(SW), .CLK_PER_US(CPU),
        .ON_US(ONU), .OFF_US(OFFU), .SETTLE_W(8), .DEAD_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_trig_i(ext_trig), .sw_trig_i(sw_trig),
        .samples_i(samples), .threshold_i(threshold), .src_enable_i(enable),
        .settle_us_i(settle), .dead_cycles_i(dead), .clk_sel_req_i(clk_sel_req),
        .trig_o(trig), .trig_src_o(trig_src), .pwr_en_o(pwr_en), .clk_sel_o(clk_sel)
    );

    always @(negedge clk) if (trig) trig_count++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_power_rise();
        while (pwr_en !== 1'b0) @(negedge clk);
        while (pwr_en !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_armed();
        wait_power_rise();
        repeat (SETTLE*CPU + 4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check("R1 pwr_en", int'(pwr_en), 0);
        check("R1 trig", int'(trig), 0);
        check("R1 tag", int'(trig_src), 0);
        check("R1 clk_sel", int'(clk_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pwr_en after reset", int'(pwr_en), 0);
    endtask

    task automatic t_power_window();
        int n_on;
        int n_off;
        n_on = 0;
        n_off = 0;
        wait_power_rise();
        while (pwr_en === 1'b1) begin n_on++; @(negedge clk); end
        while (pwr_en === 1'b0) begin n_off++; @(negedge clk); end
        check("R2 on cycles", n_on, ONU*CPU);
        check("R2 off cycles", n_off, OFFU*CPU);
    endtask

    task automatic t_ext();
        int c0;
        wait_armed();
        c0 = trig_count;
        ext_trig = 1'b1;
        idle(2);
        check("R5 ext trig", int'(trig), 1);
        check("R5 ext tag", int'(trig_src), 1);
        idle(1);
        check("R11 pulse ends", int'(trig), 0);
        idle(30);
        check("R5 level one trigger", trig_count - c0, 1);
        ext_trig = 1'b0;
        idle(10);
    endtask

    task automatic t_self();
        int c0;
        wait_armed();
        c0 = trig_count;
        samples[7*SW +: SW] = 10'd500;
        idle(8);
        check("R6 equal no fire", trig_count - c0, 0);
        samples[7*SW +: SW] = 10'd501;
        idle(2);
        check("R6 self trig", int'(trig), 1);
        check("R6 self tag", int'(trig_src), 2);
        samples[31*SW +: SW] = 10'd1023;
        idle(20);
        check("R6 sustained one", trig_count - c0, 1);
        samples = '0;
        idle(3);
        samples[31*SW +: SW] = 10'd600;
        idle(2);
        check("R6 refire ch31", int'(trig), 1);
        samples = '0;
        idle(10);
    endtask

    task automatic sw_pulse();
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    task automatic t_sw_dead();
        int c0;
        wait_armed();
        c0 = trig_count;
        sw_pulse();
        @(negedge clk);
        check("R7 sw trig", int'(trig), 1);
        check("R7 sw tag", int'(trig_src), 3);
        sw_pulse();
        idle(8);
        check("R10 dropped in dead", trig_count - c0, 1);
        sw_pulse();
        @(negedge clk);
        check("R10 fires after dead", int'(trig), 1);
        idle(10);
    endtask

    task automatic t_priority_mask();
        int c0;
        wait_armed();
        ext_trig = 1'b1;
        sw_pulse();
        @(negedge clk);
        check("R9 ext over sw", int'(trig_src), 1);
        ext_trig = 1'b0;
        idle(10);
        enable = 3'b110;
        ext_trig = 1'b1;
        sw_pulse();
        @(negedge clk);
        check("R8 ext masked, sw tag", int'(trig_src), 3);
        ext_trig = 1'b0;
        idle(10);
        c0 = trig_count;
        enable = 3'b011;
        sw_pulse();
        idle(6);
        check("R8 sw masked", trig_count - c0, 0);
        enable = 3'b111;
        idle(4);
    endtask

    task automatic t_settle();
        int c0;
        wait_power_rise();
        c0 = trig_count;
        sw_pulse();
        idle(4);
        check("R4 ignored while settling", trig_count - c0, 0);
        idle(SETTLE*CPU);
        sw_pulse();
        @(negedge clk);
        check("R4 accepted after settle", int'(trig), 1);
        idle(10);
    endtask

    task automatic t_power_off();
        int c0;
        while (pwr_en !== 1'b1) @(negedge clk);
        while (pwr_en !== 1'b0) @(negedge clk);
        c0 = trig_count;
        ext_trig = 1'b1;
        sw_pulse();
        samples[3*SW +: SW] = 10'd900;
        idle(20);
        check("R3 no trig while off", trig_count - c0, 0);
        ext_trig = 1'b0;
        samples = '0;
    endtask

    task automatic t_clk_sel();
        wait_armed();
        clk_sel_req = 1'b1;
        idle(5);
        check("R12 held while on", int'(clk_sel), 0);
        while (pwr_en !== 1'b0) @(negedge clk);
        idle(2);
        check("R12 follows while off", int'(clk_sel), 1);
    endtask

    initial begin
        t_reset();
        t_power_window();
        t_ext();
        t_self();
        t_sw_dead();
        t_priority_mask();
        t_settle();
        t_power_off();
        t_clk_sel();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule